// File: doc/BRIEF.md
# Fixed-Frame 32-bit Packet Transfer Controller

This block runs one complete transfer between a simplified host and a single addressed target. Every transfer moves exactly eight packets, and every packet is one 32-bit word. A CPU-side strobe starts the transfer and selects its direction and a 4-bit target. The block then sends a command token and runs the data phase. For a write it draws eight 16-bit payloads from a transmit FIFO. For a read it pushes eight received payloads into a receive FIFO. It closes the transfer with an acknowledge or reject handshake.

Packets enter and leave through a word-wide valid/ready interface. A separate serialiser handles line coding and bit stuffing. Every packet carries a SYNC pattern, a 3-bit packet number, the target address, a 16-bit payload and a 5-bit CRC. While the block waits for the far side, a turnaround timer counts bit times. If nothing arrives in time, the transfer is abandoned. A small status set reports completion, CRC or framing trouble, sequence trouble, a rejected transfer and a timeout. A new start clears that status.

Top module: `pkt32_xfer_ctrl`

## Requirements
- R1: Word layout: bits [31:28] hold SYNC `0001`, bits [27:25] the packet number, bits [24:21] the target, bits [20:5] the payload and bits [4:0] the CRC. The CRC uses generator x^5+x^2+1. It is computed over bits [27:5] in order from bit 27 down to bit 5, with the register preset to `11111`. The final remainder is inverted before it is placed in the word.
- R2: A `cmd_start` pulse while idle latches `cmd_write` and `cmd_target`, raises `cmd_busy` on the next edge and clears all status bits. A `cmd_start` pulse while busy has no effect.
- R3: The first packet of every transfer is the token. It has packet number 0, the latched target, and payload 0x000D for a write or 0x0009 for a read.
- R4: A write sends eight data packets numbered 0 to 7. Their payloads are the successive transmit FIFO words. One word is popped per accepted packet. The block stalls while the FIFO is empty. It holds an offered word stable until `pkt_out_ready` is high.
- R5: After a write the block waits for one handshake packet. If the packet has a bad CRC or SYNC, `st_crc_err` is set. If the packet is good and its payload is not ACK (0x004B), `st_nack` is set. If the packet is a good ACK, no error bit is set.
- R6: A read accepts eight incoming packets. The payload of each one is written to the receive FIFO in arrival order, in the same cycle it arrives.
- R7: During a read, an incoming packet with a bad CRC or SYNC sets `st_crc_err`. A packet whose number differs from the expected count 0..7, or whose target field differs from the latched target, sets `st_seq_err`.
- R8: After the eighth read packet the host sends a handshake with packet number 0 and the target. Its payload is ACK (0x004B) if no error was seen, otherwise NACK (0x005A). Sending NACK also sets `st_nack`.
- R9: While awaiting a packet, the block ends the transfer with `st_timeout` set if nothing arrives within 17 bit times of `CLKS_PER_BIT` clocks each. The count starts from the previous packet, which is the last one sent or received. No handshake is sent after a timeout.
- R10: After reset the block is idle with all status bits clear. Every transfer ends by lowering `cmd_busy` and raising `st_done` on the same edge. The status then holds until the next start.
- R11: Incoming packets that arrive while the block is not awaiting one are ignored. They cause no FIFO write and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_start | input | 1 | Start strobe |
| cmd_write | input | 1 | 1 = write transfer, 0 = read |
| cmd_target | input | 4 | Target address |
| cmd_busy | output | 1 | Start command still in progress |
| st_done | output | 1 | Last transfer finished |
| st_crc_err | output | 1 | CRC or SYNC failure seen |
| st_seq_err | output | 1 | Packet number or target mismatch on read |
| st_nack | output | 1 | Transfer rejected (received or sent NACK) |
| st_timeout | output | 1 | Turnaround timer expired |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_data | input | 16 | Transmit FIFO head word |
| txf_rd | output | 1 | Transmit FIFO pop |
| rxf_wr | output | 1 | Receive FIFO push |
| rxf_data | output | 16 | Receive FIFO write data |
| pkt_out_valid | output | 1 | Outgoing packet offered |
| pkt_out_ready | input | 1 | Serialiser accepts the packet |
| pkt_out_word | output | 32 | Outgoing packet |
| pkt_in_valid | input | 1 | Incoming packet present (one cycle) |
| pkt_in_word | input | 32 | Incoming packet |

## Verification
The token is offered in the cycle after the start edge. FIFO pops coincide with the accepting edge, and receive FIFO pushes coincide with the arrival cycle. The bench therefore logs packets and pushes at each rising edge and compares the logs after the transfer. Status is due at the edge that drops `cmd_busy`, so every status check waits for that fall and samples on the following falling edge. The timeout is due 17 bit times after the last accepted packet plus one register stage. The bench measures the gap between that packet's logged edge and the fall of `cmd_busy`, and requires it to lie within 16 to 18 bit times plus two cycles of latency.

// File: rtl/pkt32_pkg.sv
package pkt32_pkg;
   localparam int WORD_W = 32;
   localparam int SYNC_W = 4;
   localparam int NUM_W  = 3;
   localparam int ADDR_W = 4;
   localparam int PAY_W  = 16;
   localparam int CRC_W  = 5;
   localparam int BODY_W = NUM_W + ADDR_W + PAY_W;
   localparam int N_PKT  = 1 << NUM_W;

   localparam logic [SYNC_W-1:0] SYNC_PAT = 4'b0001;
   localparam logic [CRC_W-1:0]  CRC_POLY = 5'b00101; // x^2 + 1 terms of x^5+x^2+1

   typedef struct packed {
      logic [NUM_W-1:0]  num;
      logic [ADDR_W-1:0] addr;
      logic [PAY_W-1:0]  pay;
   } pkt_body_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_TOKEN,
      S_WDATA,
      S_WACK,
      S_RDATA,
      S_RACK
   } xfer_state_t;

   // Serial CRC-5 over the body, most significant bit first, preset ones.
   function automatic logic [CRC_W-1:0] crc5_raw(input logic [BODY_W-1:0] body);
      logic [CRC_W-1:0] r;
      logic fb;
      r = '1;
      for (int i = BODY_W - 1; i >= 0; i--) begin
         fb = body[i] ^ r[CRC_W-1];
         r  = {r[CRC_W-2:0], 1'b0};
         if (fb) r = r ^ CRC_POLY;
      end
      return r;
   endfunction
endpackage

// File: rtl/pkt32_build.sv
module pkt32_build
   import pkt32_pkg::*;
#(
   parameter bit CRC_INVERT = 1'b1
) (
   input  pkt_body_t          body,
   output logic [WORD_W-1:0]  word
);
   logic [CRC_W-1:0] raw;
   assign raw = crc5_raw(body);

   generate
      if (CRC_INVERT) begin : g_inv
         assign word = {SYNC_PAT, body, ~raw};
      end else begin : g_plain
         assign word = {SYNC_PAT, body, raw};
      end
   endgenerate
endmodule

// File: rtl/pkt32_parse.sv
module pkt32_parse
   import pkt32_pkg::*;
#(
   parameter bit CRC_INVERT = 1'b1
) (
   input  logic [WORD_W-1:0] word,
   output pkt_body_t         body,
   output logic              good
);
   logic [CRC_W-1:0] raw;
   logic [CRC_W-1:0] want;

   assign body = word[CRC_W +: BODY_W];
   assign raw  = crc5_raw(word[CRC_W +: BODY_W]);

   generate
      if (CRC_INVERT) begin : g_inv
         assign want = ~raw;
      end else begin : g_plain
         assign want = raw;
      end
   endgenerate

   assign good = (word[WORD_W-1 -: SYNC_W] == SYNC_PAT) && (word[CRC_W-1:0] == want);
endmodule

// File: rtl/pkt32_turn_timer.sv
module pkt32_turn_timer #(
   parameter int CLKS_PER_BIT = 4,
   parameter int TURN_BITS    = 17
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic run,
   output logic expired
);
   localparam int CNT_W = $clog2(TURN_BITS + 1);

   logic [CNT_W-1:0] bits_q;
   logic             bit_tick;

   generate
      if (CLKS_PER_BIT == 1) begin : g_direct
         assign bit_tick = run && !arm;
      end else begin : g_div
         localparam int PRE_W = $clog2(CLKS_PER_BIT);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_BIT - 1);
         logic [PRE_W-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (arm) begin
               pre_q <= '0;
            end else if (run) begin
               pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
            end
         end

         assign bit_tick = run && !arm && (pre_q == PRE_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_q <= '0;
      end else if (arm) begin
         bits_q <= '0;
      end else if (bit_tick && (bits_q != CNT_W'(TURN_BITS))) begin
         bits_q <= bits_q + 1'b1;
      end
   end

   assign expired = run && !arm && (bits_q == CNT_W'(TURN_BITS));
endmodule

// File: rtl/pkt32_xfer_ctrl.sv
module pkt32_xfer_ctrl
   import pkt32_pkg::*;
#(
   parameter int               CLKS_PER_BIT = 4,
   parameter int               TURN_BITS    = 17,
   parameter bit               CRC_INVERT   = 1'b1,
   parameter logic [PAY_W-1:0] RD_CODE      = 16'h0009,
   parameter logic [PAY_W-1:0] WR_CODE      = 16'h000D,
   parameter logic [PAY_W-1:0] ACK_CODE     = 16'h004B,
   parameter logic [PAY_W-1:0] NACK_CODE    = 16'h005A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_target,
   output logic              cmd_busy,
   output logic              st_done,
   output logic              st_crc_err,
   output logic              st_seq_err,
   output logic              st_nack,
   output logic              st_timeout,
   input  logic              txf_empty,
   input  logic [PAY_W-1:0]  txf_data,
   output logic              txf_rd,
   output logic              rxf_wr,
   output logic [PAY_W-1:0]  rxf_data,
   output logic              pkt_out_valid,
   input  logic              pkt_out_ready,
   output logic [WORD_W-1:0] pkt_out_word,
   input  logic              pkt_in_valid,
   input  logic [WORD_W-1:0] pkt_in_word
);
   localparam logic [NUM_W-1:0] LAST_NUM = NUM_W'(N_PKT - 1);

   initial begin
      assert (TURN_BITS >= 16 && TURN_BITS <= 18)
         else $error("TURN_BITS must lie in 16..18");
      assert (CLKS_PER_BIT >= 1) else $error("CLKS_PER_BIT must be positive");
      assert (SYNC_W + BODY_W + CRC_W == WORD_W) else $error("packet fields must fill the word");
      assert (RD_CODE != WR_CODE) else $error("read and write codes must differ");
      assert (ACK_CODE != NACK_CODE) else $error("handshake codes must differ");
   end

   xfer_state_t       state_q;
   logic              wr_q;
   logic [ADDR_W-1:0] tgt_q;
   logic [NUM_W-1:0]  idx_q;
   logic              done_q, crc_q, seq_q, nack_q, to_q;

   pkt_body_t out_body;
   pkt_body_t in_body;
   logic      in_good;
   logic      out_fire;
   logic      last_idx;
   logic      tmr_arm, tmr_run, tmr_expired;

   // Outgoing packet selection
   always_comb begin
      out_body.num  = '0;
      out_body.addr = tgt_q;
      out_body.pay  = wr_q ? WR_CODE : RD_CODE;
      unique case (state_q)
         S_WDATA: begin
            out_body.num = idx_q;
            out_body.pay = txf_data;
         end
         S_RACK: begin
            out_body.pay = (crc_q || seq_q) ? NACK_CODE : ACK_CODE;
         end
         default: ;
      endcase
   end

   assign pkt_out_valid = (state_q == S_TOKEN) || (state_q == S_RACK) ||
                          ((state_q == S_WDATA) && !txf_empty);
   assign out_fire      = pkt_out_valid && pkt_out_ready;
   assign txf_rd        = (state_q == S_WDATA) && out_fire;
   assign last_idx      = (idx_q == LAST_NUM);

   pkt32_build #(.CRC_INVERT(CRC_INVERT)) u_build (
      .body (out_body),
      .word (pkt_out_word)
   );

   pkt32_parse #(.CRC_INVERT(CRC_INVERT)) u_parse (
      .word (pkt_in_word),
      .body (in_body),
      .good (in_good)
   );

   // Receive path: only while awaiting read data
   assign rxf_wr   = (state_q == S_RDATA) && pkt_in_valid;
   assign rxf_data = in_body.pay;

   // Turnaround timer restarts at every packet boundary that opens a wait
   assign tmr_arm = ((state_q == S_TOKEN) && out_fire && !wr_q) ||
                    ((state_q == S_WDATA) && out_fire && last_idx) ||
                    ((state_q == S_RDATA) && pkt_in_valid);
   assign tmr_run = (state_q == S_WACK) || (state_q == S_RDATA);

   pkt32_turn_timer #(
      .CLKS_PER_BIT (CLKS_PER_BIT),
      .TURN_BITS    (TURN_BITS)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (tmr_arm),
      .run     (tmr_run),
      .expired (tmr_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         wr_q    <= 1'b0;
         tgt_q   <= '0;
         idx_q   <= '0;
         done_q  <= 1'b0;
         crc_q   <= 1'b0;
         seq_q   <= 1'b0;
         nack_q  <= 1'b0;
         to_q    <= 1'b0;
      end else begin
         unique case (state_q)
            S_IDLE: begin
               if (cmd_start) begin
                  wr_q    <= cmd_write;
                  tgt_q   <= cmd_target;
                  idx_q   <= '0;
                  done_q  <= 1'b0;
                  crc_q   <= 1'b0;
                  seq_q   <= 1'b0;
                  nack_q  <= 1'b0;
                  to_q    <= 1'b0;
                  state_q <= S_TOKEN;
               end
            end
            S_TOKEN: begin
               if (out_fire) begin
                  idx_q   <= '0;
                  state_q <= wr_q ? S_WDATA : S_RDATA;
               end
            end
            S_WDATA: begin
               if (out_fire) begin
                  idx_q <= idx_q + 1'b1;
                  if (last_idx) state_q <= S_WACK;
               end
            end
            S_WACK: begin
               if (pkt_in_valid) begin
                  if (!in_good) crc_q <= 1'b1;
                  else if (in_body.pay != ACK_CODE) nack_q <= 1'b1;
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else if (tmr_expired) begin
                  to_q    <= 1'b1;
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end
            end
            S_RDATA: begin
               if (pkt_in_valid) begin
                  if (!in_good) crc_q <= 1'b1;
                  if ((in_body.num != idx_q) || (in_body.addr != tgt_q)) seq_q <= 1'b1;
                  idx_q <= idx_q + 1'b1;
                  if (last_idx) state_q <= S_RACK;
               end else if (tmr_expired) begin
                  to_q    <= 1'b1;
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end
            end
            S_RACK: begin
               if (out_fire) begin
                  nack_q  <= crc_q || seq_q;
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign cmd_busy   = (state_q != S_IDLE);
   assign st_done    = done_q;
   assign st_crc_err = crc_q;
   assign st_seq_err = seq_q;
   assign st_nack    = nack_q;
   assign st_timeout = to_q;
endmodule

// File: rtl/pkt32_xfer_ctrl_chk.sv
module pkt32_xfer_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_start,
   input logic        cmd_busy,
   input logic        st_done,
   input logic        st_crc_err,
   input logic        st_timeout,
   input logic        txf_empty,
   input logic        txf_rd,
   input logic        rxf_wr,
   input logic        pkt_in_valid,
   input logic        pkt_out_valid,
   input logic        pkt_out_ready,
   input logic [31:0] pkt_out_word
);
   a_r1_sync_lead: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_out_valid |-> (pkt_out_word[31:28] == 4'b0001));

   a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && !cmd_busy) |=> (cmd_busy && !st_done && !st_crc_err && !st_timeout));

   a_r4_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_out_valid && !pkt_out_ready) |=> (pkt_out_valid && $stable(pkt_out_word)));

   a_r4_pop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      txf_rd |-> (pkt_out_valid && pkt_out_ready && !txf_empty));

   a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_busy |-> (!pkt_out_valid && !txf_rd));

   a_r10_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_busy) |-> st_done);

   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      st_done |-> !cmd_busy);

   a_r9_timeout_ends: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_timeout) |-> (st_done && !cmd_busy));

   a_r11_push_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rxf_wr |-> (cmd_busy && pkt_in_valid));
endmodule

bind pkt32_xfer_ctrl pkt32_xfer_ctrl_chk u_chk (.*);

// File: tb/pkt32_xfer_ctrl_bench.sv
module pkt32_xfer_ctrl_bench;
   localparam int CPB = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic        cmd_write = 1'b0;
   logic [3:0]  cmd_target = '0;
   logic        cmd_busy, st_done, st_crc_err, st_seq_err, st_nack, st_timeout;
   logic        txf_empty;
   logic [15:0] txf_data;
   logic        txf_rd;
   logic        rxf_wr;
   logic [15:0] rxf_data;
   logic        pkt_out_valid;
   logic        pkt_out_ready = 1'b1;
   logic [31:0] pkt_out_word;
   logic        pkt_in_valid = 1'b0;
   logic [31:0] pkt_in_word = '0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   int seed_val;

   always #4 clk = ~clk;

   pkt32_xfer_ctrl #(.CLKS_PER_BIT(CPB)) u_pkt32_xfer_ctrl (.*);

   // Cycle counter and logs
   int          cyc = 0;
   logic [31:0] out_log [0:1023];
   int          out_t   [0:1023];
   int          out_n = 0;
   logic [15:0] rx_log  [0:1023];
   int          rx_n = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      if (rst_n && pkt_out_valid && pkt_out_ready) begin
         out_log[out_n] <= pkt_out_word;
         out_t[out_n]   <= cyc;
         out_n          <= out_n + 1;
      end
      if (rst_n && rxf_wr) begin
         rx_log[rx_n] <= rxf_data;
         rx_n         <= rx_n + 1;
      end
   end

   // Transmit FIFO model
   logic [15:0] tx_mem [0:255];
   logic [7:0]  tx_wr = '0;
   logic [7:0]  tx_rd = '0;
   assign txf_empty = (tx_wr == tx_rd);
   assign txf_data  = tx_mem[tx_rd];
   always @(posedge clk) if (txf_rd) tx_rd <= tx_rd + 1'b1;

   // Random backpressure on the outgoing side
   always @(negedge clk) pkt_out_ready <= (($urandom % 3) != 0);

   // Reference packet construction from R1
   function automatic logic [4:0] ref_crc(input logic [22:0] body);
      logic [4:0] lf;
      logic       b;
      lf = 5'b11111;
      for (int k = 0; k < 23; k++) begin
         b  = body[22 - k] ^ lf[4];
         lf = {lf[3], lf[2], lf[1] ^ b, lf[0], b};
      end
      return ~lf;
   endfunction

   function automatic logic [31:0] mk(input logic [2:0] num, input logic [3:0] addr,
                                      input logic [15:0] pay);
      return {4'b0001, num, addr, pay, ref_crc({num, addr, pay})};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic chk_range(input string req, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d..%0d", req, act, lo, hi);
      end
   endtask

   function automatic logic [31:0] flags();
      return {27'b0, st_done, st_crc_err, st_seq_err, st_nack, st_timeout};
   endfunction

   task automatic push_tx(input logic [15:0] w);
      tx_mem[tx_wr] = w;
      tx_wr = tx_wr + 1'b1;
   endtask

   task automatic start_cmd(input bit wr, input logic [3:0] tgt);
      @(negedge clk);
      cmd_start = 1'b1; cmd_write = wr; cmd_target = tgt;
      @(negedge clk);
      cmd_start = 1'b0; cmd_write = ~wr; cmd_target = ~tgt;
   endtask

   task automatic send_in(input logic [31:0] w);
      @(negedge clk);
      pkt_in_valid = 1'b1; pkt_in_word = w;
      @(negedge clk);
      pkt_in_valid = 1'b0; pkt_in_word = $urandom;
   endtask

   task automatic wait_out(input int n);
      while (out_n < n) @(negedge clk);
   endtask

   task automatic wait_idle();
      while (cmd_busy) @(negedge clk);
   endtask

   // kind: 0 ACK, 1 other payload, 2 corrupted CRC, 3 no response
   task automatic do_write(input logic [3:0] tgt, input int kind, input bit stall, input bit poke);
      logic [15:0] w [8];
      int base, t0;
      logic [31:0] hs;
      base = out_n;
      foreach (w[i]) w[i] = 16'($urandom);
      for (int i = 0; i < (stall ? 4 : 8); i++) push_tx(w[i]);
      start_cmd(1'b1, tgt);
      chk("R2 start clears status", {26'b0, cmd_busy, flags()[4:0]}, 32'h20);
      if (poke) start_cmd(1'b0, tgt ^ 4'h5);
      if (stall) begin
         repeat (40) @(negedge clk);
         chk("R4 stall on empty FIFO", out_n - base, 5);
         for (int i = 4; i < 8; i++) push_tx(w[i]);
      end
      wait_out(base + 9);
      chk("R3 write token", out_log[base], mk(3'd0, tgt, 16'h000D));
      for (int i = 0; i < 8; i++)
         chk("R4 R1 write data packet", out_log[base + 1 + i], mk(3'(i), tgt, w[i]));
      t0 = out_t[base + 8];
      if (kind != 3) begin
         repeat (1 + $urandom % 10) @(negedge clk);
         hs = mk(3'd0, tgt, (kind == 1) ? 16'h1234 : 16'h004B);
         if (kind == 2) hs = hs ^ 32'h1;
         send_in(hs);
      end
      wait_idle();
      chk("R5 R9 R10 write status", flags(),
          {27'b0, 1'b1, kind == 2, 1'b0, kind == 1, kind == 3});
      if (kind == 3) chk_range("R9 timeout delay", cyc - t0, 16 * CPB, 18 * CPB + 2);
      repeat (10) @(negedge clk);
      chk("R2 single token per start", out_n - base, 9);
   endtask

   // mode: 0 clean, 1 bad CRC at k, 2 bad number at k, 3 silence from k
   task automatic do_read(input logic [3:0] tgt, input int mode, input int k);
      logic [15:0] p [8];
      int base, rbase, npk;
      logic [31:0] pw;
      base  = out_n;
      rbase = rx_n;
      npk   = (mode == 3) ? k : 8;
      start_cmd(1'b0, tgt);
      chk("R2 start clears status", {26'b0, cmd_busy, flags()[4:0]}, 32'h20);
      wait_out(base + 1);
      chk("R3 read token", out_log[base], mk(3'd0, tgt, 16'h0009));
      for (int i = 0; i < npk; i++) begin
         repeat (1 + $urandom % 12) @(negedge clk);
         p[i] = 16'($urandom);
         pw = mk((mode == 2 && i == k) ? 3'(i + 1) : 3'(i), tgt, p[i]);
         if (mode == 1 && i == k) pw = pw ^ 32'h2;
         send_in(pw);
      end
      if (mode != 3) begin
         wait_out(base + 2);
         chk("R8 read handshake", out_log[base + 1],
             mk(3'd0, tgt, (mode == 0) ? 16'h004B : 16'h005A));
      end
      wait_idle();
      chk("R6 receive count", rx_n - rbase, npk);
      for (int i = 0; i < npk; i++)
         chk("R6 receive payload", {16'b0, rx_log[rbase + i]}, {16'b0, p[i]});
      chk("R7 R8 R9 read status", flags(),
          {27'b0, 1'b1, mode == 1, mode == 2, mode == 1 || mode == 2, mode == 3});
      repeat (10) @(negedge clk);
      chk("R9 no handshake after timeout", out_n - base, (mode == 3) ? 1 : 2);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R10 watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      logic [31:0] f0;
      int r0;
      seed_val = $urandom(32'd20240611);
      repeat (4) @(negedge clk);
      chk("R10 reset idle", {28'b0, cmd_busy, pkt_out_valid, txf_rd, rxf_wr}, 32'h0);
      chk("R10 reset status", flags(), 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      do_write(4'h3, 0, 1'b0, 1'b0);
      do_write(4'hA, 1, 1'b0, 1'b0);
      do_write(4'h0, 2, 1'b0, 1'b0);
      do_write(4'hF, 3, 1'b0, 1'b0);
      do_write(4'h6, 0, 1'b1, 1'b0);
      do_write(4'h9, 0, 1'b0, 1'b1);
      do_read(4'h1, 0, 0);
      do_read(4'hC, 1, 3);
      do_read(4'h7, 2, 0);
      do_read(4'h2, 2, 7);
      do_read(4'h5, 3, 3);
      do_read(4'hE, 3, 0);

      // R11: packet while idle is ignored
      f0 = flags();
      r0 = rx_n;
      send_in(mk(3'd0, 4'hE, 16'hBEEF));
      repeat (3) @(negedge clk);
      chk("R11 idle packet no push", rx_n - r0, 0);
      chk("R11 idle packet no status change", flags(), f0);
      chk("R11 idle packet stays idle", {31'b0, cmd_busy}, 0);

      for (int it = 0; it < 14; it++) begin
         if ($urandom % 2) do_write(4'($urandom), $urandom % 4, 1'b0, 1'b0);
         else do_read(4'($urandom), $urandom % 4, $urandom % 8);
      end

      finish_run();
   end
endmodule